// File: doc/BRIEF.md
# Control Channel Phase Sequencer

This block decides when a serial video link stops carrying pixels and opens a window for host configuration traffic, and when it goes back. While the link is in its video phase, a programmable edge of the frame sync input opens the control window. The window stays open as long as the host keeps talking. Two inactivity timers close it:

- The first timer covers the wait for the host's first transaction.
- The second timer runs from the host's most recent transaction.

Both timers count ticks of a divided pixel clock. Host traffic is reported to the block as a single-cycle activity pulse. Decoding the host commands happens elsewhere.

When the window closes, the block emits a burst of handshake words. The receiver uses this burst to lock its clock recovery. The burst has one of two fixed lengths. Once the last word has gone out, video resumes.

The handshake word strobe is a valid-only stream with no ready. One word leaves on every cycle of the burst and the consumer cannot apply back-pressure, so the downstream serializer must accept a word on every clock while the strobe is high. All other pins are plain control and status.

Top module: `ccs_sequencer`

## Requirements
- R1: Select `vsync_rise_sel` = 0 makes a falling edge of `vsync` the active edge, and 1 makes a rising edge active. An active edge in the video phase puts `phase` to control in the cycle after the clock edge that first samples the new `vsync` level. The opposite edge has no effect.
- R2: `phase` is encoded as video = 2'd0, control = 2'd1 and handshake = 2'd2. `chan_open` is high in exactly the cycles where `phase` is control.
- R3: If no activity pulse arrives, the control phase lasts exactly (c+1)·2^d cycles. Here d is `start_div` and c is `start_cnt`.
- R4: Each `host_act` pulse during the control phase restarts timing. After the first pulse, the end timer applies. The control phase ends exactly (c+1)·2^d cycles after the clock edge that samples the last pulse, with d = `end_div` and c = `end_cnt`. A pulse never closes the window.
- R5: Divider code 4'b1010 gives a tick every 1024 pixel clocks. Codes above 4'b1010 behave as 4'b1010.
- R6: Count code 4'b0000 closes the window on the first tick. Count code c closes it on tick c+1.
- R7: `hsk_word` is high for exactly 546 consecutive cycles when `hsk_long_sel` was 0 at the close, and 1090 when it was 1. The burst starts in the first cycle after control ends and is followed directly by the video phase. Changes of `hsk_long_sel` during a burst do not alter its length.
- R8: `vsync` edges seen during the control or handshake phases are ignored. They neither lengthen the window nor reopen it after the burst.
- R9: After reset, `phase` is video, and `chan_open` and `hsk_word` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | Frame sync, synchronous to clk |
| vsync_rise_sel | input | 1 | Active edge select: 0 falling, 1 rising |
| host_act | input | 1 | One-cycle pulse per host transaction |
| start_div | input | 4 | Divider code of the first-activity timer |
| start_cnt | input | 4 | Count code of the first-activity timer |
| end_div | input | 4 | Divider code of the after-activity timer |
| end_cnt | input | 4 | Count code of the after-activity timer |
| hsk_long_sel | input | 1 | Handshake length: 0 gives 546 words, 1 gives 1090 words |
| chan_open | output | 1 | Control window open |
| phase | output | 2 | Current phase: 0 video, 1 control, 2 handshake |
| hsk_word | output | 1 | Handshake word valid, one word per cycle |

## Verification
The bench goes after the following corner cases:

- **Timer arithmetic.** It measures exact window lengths with a divide of one and a count of one, and with the largest divide and a clamped divide code. An off-by-one in either the prescaler or the tick counter shows up as a window one tick or one clock too long or short.
- **Timer selection.** It sends activity pulses late in a window that would otherwise close on the start timer. A design that keeps using the start timer, or lets a pulse close the window, gives the wrong length.
- **Ignored sync edges.** It toggles `vsync` with the active polarity during the window and during the burst. A design that re-enters control then shows a second window or a lengthened window.
- **Handshake length.** It flips the length select in the middle of a burst. A design that does not hold the select from the close emits a truncated burst.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  typedef enum logic [1:0] {
    PH_VIDEO = 2'd0,
    PH_CTRL  = 2'd1,
    PH_HSK   = 2'd2
  } phase_e;

  localparam int unsigned N_TIMERS  = 2;
  localparam int unsigned TMR_START = 0;
  localparam int unsigned TMR_END   = 1;

endpackage

// File: rtl/ccs_edge_detect.sv
module ccs_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  input  logic rise_sel,
  output logic hit
);

  logic d1_q;
  logic armed_q;

  // The first sample after reset only primes the history register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      d1_q    <= sig;
      armed_q <= 1'b1;
    end
  end

  always_comb begin
    if (rise_sel) hit = armed_q & sig & ~d1_q;
    else          hit = armed_q & ~sig & d1_q;
  end

endmodule

// File: rtl/ccs_idle_timer.sv
module ccs_idle_timer #(
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned DIV_MAX = 10,
  parameter int unsigned CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [DIV_W-1:0] div_code,
  input  logic [CNT_W-1:0] cnt_code,
  output logic             expire
);

  localparam int unsigned PRE_W = (DIV_MAX < 1) ? 1 : DIV_MAX;
  localparam logic [PRE_W:0] ONE_W = {{PRE_W{1'b0}}, 1'b1};
  localparam logic [DIV_W-1:0] DIV_CAP = DIV_W'(DIV_MAX);

  logic [DIV_W-1:0] div_eff;
  logic [PRE_W:0]   span_w;
  logic [PRE_W:0]   lim_w;
  logic [PRE_W-1:0] pre_lim;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  // Divider codes beyond the supported range are clamped to the slowest rate.
  assign div_eff = (div_code > DIV_CAP) ? DIV_CAP : div_code;
  assign span_w  = ONE_W << div_eff;
  assign lim_w   = span_w - ONE_W;
  assign pre_lim = lim_w[PRE_W-1:0];

  assign tick   = run & ~clear & (pre_q == pre_lim);
  assign expire = tick & (cnt_q == cnt_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (run) begin
      if (pre_q == pre_lim) begin
        pre_q <= '0;
        cnt_q <= expire ? '0 : cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R4: a restart leaves the prescaler at its start point.
  assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pre_q == '0) && (cnt_q == '0));

endmodule

// File: rtl/ccs_hsk_burst.sv
module ccs_hsk_burst #(
  parameter int unsigned SHORT_LEN = 546,
  parameter int unsigned LONG_LEN  = 1090
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  output logic active,
  output logic done
);

  localparam int unsigned IDX_W = $clog2(LONG_LEN);
  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_LEN - 1);
  localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_LEN - 1);

  logic             active_q;
  logic             sel_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_idx;

  // The length select is captured when the burst starts.
  assign last_idx = sel_q ? LONG_LAST : SHORT_LAST;
  assign done     = active_q & (idx_q == last_idx);
  assign active   = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sel_q    <= 1'b0;
      idx_q    <= '0;
    end else if (start && !active_q) begin
      active_q <= 1'b1;
      sel_q    <= long_sel;
      idx_q    <= '0;
    end else if (active_q) begin
      if (done) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R7: a burst only ever ends after one of the two legal word counts.
  assert_burst_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> ($past(idx_q) == SHORT_LAST) || ($past(idx_q) == LONG_LAST));

endmodule

// File: rtl/ccs_sequencer.sv
module ccs_sequencer #(
  parameter int unsigned DIV_W     = 4,
  parameter int unsigned DIV_MAX   = 10,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned SHORT_LEN = 546,
  parameter int unsigned LONG_LEN  = 1090
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync,
  input  logic             vsync_rise_sel,
  input  logic             host_act,
  input  logic [DIV_W-1:0] start_div,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic [DIV_W-1:0] end_div,
  input  logic [CNT_W-1:0] end_cnt,
  input  logic             hsk_long_sel,
  output logic             chan_open,
  output logic [1:0]       phase,
  output logic             hsk_word
);

  import ccs_pkg::*;

  phase_e phase_q, phase_d;
  logic   edge_hit;
  logic   seen_q;
  logic   in_ctrl;
  logic   enter;
  logic   tmr_clear;
  logic   close;
  logic   burst_done;
  logic   burst_active;

  logic [N_TIMERS-1:0]            t_run;
  logic [N_TIMERS-1:0]            t_exp;
  logic [N_TIMERS-1:0][DIV_W-1:0] t_div;
  logic [N_TIMERS-1:0][CNT_W-1:0] t_cnt;

  ccs_edge_detect u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig      (vsync),
    .rise_sel (vsync_rise_sel),
    .hit      (edge_hit)
  );

  assign in_ctrl   = (phase_q == PH_CTRL);
  assign enter     = (phase_q == PH_VIDEO) & edge_hit;
  assign tmr_clear = enter | (in_ctrl & host_act);

  assign t_div[TMR_START] = start_div;
  assign t_cnt[TMR_START] = start_cnt;
  assign t_div[TMR_END]   = end_div;
  assign t_cnt[TMR_END]   = end_cnt;
  assign t_run[TMR_START] = in_ctrl & ~seen_q;
  assign t_run[TMR_END]   = in_ctrl & seen_q;

  // One inactivity timer per window stage.
  for (genvar t = 0; t < N_TIMERS; t++) begin : g_tmr
    ccs_idle_timer #(
      .DIV_W   (DIV_W),
      .DIV_MAX (DIV_MAX),
      .CNT_W   (CNT_W)
    ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (t_run[t]),
      .clear    (tmr_clear),
      .div_code (t_div[t]),
      .cnt_code (t_cnt[t]),
      .expire   (t_exp[t])
    );
  end

  assign close = in_ctrl & (|t_exp);

  ccs_hsk_burst #(
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN)
  ) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (close),
    .long_sel (hsk_long_sel),
    .active   (burst_active),
    .done     (burst_done)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_VIDEO: if (edge_hit)   phase_d = PH_CTRL;
      PH_CTRL:  if (close)      phase_d = PH_HSK;
      PH_HSK:   if (burst_done) phase_d = PH_VIDEO;
      default:                  phase_d = PH_VIDEO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_VIDEO;
      seen_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (enter)                     seen_q <= 1'b0;
      else if (in_ctrl && host_act)  seen_q <= 1'b1;
    end
  end

  assign chan_open = in_ctrl;
  assign phase     = phase_q;
  assign hsk_word  = burst_active;

  // R1: an active edge in video opens the window on the next cycle.
  assert_edge_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_VIDEO) && edge_hit) |=> (phase_q == PH_CTRL));

  // R2: the open flag only rises on the step from video to control.
  assert_open_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_open) |-> (phase == 2'd1) && ($past(phase) == 2'd0));

  // R4: host activity keeps the window open.
  assert_activity_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ctrl && host_act) |=> (phase_q == PH_CTRL));

  // R7: the handshake burst runs in step with the handshake phase.
  assert_burst_in_hsk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HSK) |-> burst_active);

  // R8: the handshake phase can only return to video.
  assert_hsk_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HSK) |=> (phase_q == PH_HSK) || (phase_q == PH_VIDEO));

endmodule

// File: tb/ccs_sequencer_tb_top.sv
module ccs_sequencer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vsync = 1'b1;
  logic       vsync_rise_sel = 1'b0;
  logic       host_act = 1'b0;
  logic [3:0] start_div = 4'd0;
  logic [3:0] start_cnt = 4'd0;
  logic [3:0] end_div = 4'd0;
  logic [3:0] end_cnt = 4'd0;
  logic       hsk_long_sel = 1'b0;
  logic       chan_open;
  logic [1:0] phase;
  logic       hsk_word;

  always #5 clk = ~clk;

  ccs_sequencer dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .vsync          (vsync),
    .vsync_rise_sel (vsync_rise_sel),
    .host_act       (host_act),
    .start_div      (start_div),
    .start_cnt      (start_cnt),
    .end_div        (end_div),
    .end_cnt        (end_cnt),
    .hsk_long_sel   (hsk_long_sel),
    .chan_open      (chan_open),
    .phase          (phase),
    .hsk_word       (hsk_word)
  );

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit done_flag = 1'b0;

  // Scoreboard queues: one entry per expected phase run.
  logic [1:0] exp_ph_q[$];
  int         exp_len_q[$];
  string      exp_tag_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] ph, input int len, input string tag);
    exp_ph_q.push_back(ph);
    exp_len_q.push_back(len);
    exp_tag_q.push_back(tag);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  // Monitor: measures each control and handshake run and compares it.
  logic [1:0] prev_ph = 2'd0;
  int  run_len = 0;
  int  strb_cnt = 0;
  bit  open_bad = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ph = 2'd0; run_len = 0; strb_cnt = 0; open_bad = 1'b0;
    end else begin
      if (phase == prev_ph) begin
        run_len++;
      end else begin
        if (prev_ph != 2'd0) begin
          if (exp_len_q.size() == 0) begin
            chk(1'b0, "R8 unexpected run", int'(prev_ph), 0);
          end else begin
            logic [1:0] eph;
            int elen;
            string etag;
            eph  = exp_ph_q.pop_front();
            elen = exp_len_q.pop_front();
            etag = exp_tag_q.pop_front();
            chk(eph == prev_ph, {etag, " phase kind"}, int'(prev_ph), int'(eph));
            chk(run_len == elen, {etag, " run length"}, run_len, elen);
            chk(!open_bad, "R2 open flag tracks control", int'(open_bad), 0);
            if (prev_ph == 2'd2) begin
              chk(strb_cnt == elen, "R7 strobe count", strb_cnt, elen);
              chk(phase == 2'd0, "R7 returns to video", int'(phase), 0);
            end else begin
              chk(phase == 2'd2, "R7 handshake follows control", int'(phase), 2);
            end
          end
        end
        run_len = 1; strb_cnt = 0; open_bad = 1'b0;
      end
      if (hsk_word) strb_cnt++;
      if (chan_open != (phase == 2'd1)) open_bad = 1'b1;
      prev_ph = phase;
    end
  end

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  // Drives an active edge; cyc counts control-phase samples afterwards.
  task automatic open_on(input bit rise, input string req);
    vsync = rise ? 1'b0 : 1'b1;
    repeat (2) @(negedge clk);
    vsync = rise ? 1'b1 : 1'b0;
    @(negedge clk);
    cyc = 1;
    chk(phase == 2'd1, req, int'(phase), 1);
  endtask

  task automatic pulse_at(input int c0);
    while (cyc < c0) step();
    host_act = 1'b1;
    step();
    host_act = 1'b0;
  endtask

  task automatic wait_video();
    do @(negedge clk); while (phase != 2'd0);
    repeat (2) @(negedge clk);
    chk(exp_len_q.size() == 0, "R7 all runs seen", exp_len_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(phase == 2'd0, "R9 phase", int'(phase), 0);
    chk(chan_open == 1'b0, "R9 chan_open", int'(chan_open), 0);
    chk(hsk_word == 1'b0, "R9 hsk_word", int'(hsk_word), 0);

    // R3/R1: falling edge, start timer 4 x 2 = 8, short burst
    vsync_rise_sel = 1'b0; start_div = 4'd2; start_cnt = 4'd1; hsk_long_sel = 1'b0;
    push(2'd1, 8, "R3 start timeout");
    push(2'd2, 546, "R7 short burst");
    open_on(1'b0, "R1 falling edge opens");
    chk(chan_open == 1'b1, "R2 open while control", int'(chan_open), 1);
    wait_video();

    // R1: wrong polarity is ignored
    vsync = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(phase == 2'd0, "R1 rising edge ignored when falling selected", int'(phase), 0);
    end
    vsync_rise_sel = 1'b1;
    vsync = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(phase == 2'd0, "R1 falling edge ignored when rising selected", int'(phase), 0);
    end

    // R4: one pulse at sample 3, end timer 3 x 2 = 6 -> 3 + 6; long burst held
    start_div = 4'd3; start_cnt = 4'd0; end_div = 4'd1; end_cnt = 4'd2; hsk_long_sel = 1'b1;
    push(2'd1, 9, "R4 single pulse");
    push(2'd2, 1090, "R7 long burst select held");
    open_on(1'b1, "R1 rising edge opens");
    pulse_at(3);
    do @(negedge clk); while (phase != 2'd2);
    hsk_long_sel = 1'b0;
    wait_video();

    // R4/R8: pulses at 3 and 10, end timer 8 -> 18; sync edges ignored
    vsync_rise_sel = 1'b0; vsync = 1'b1;
    start_div = 4'd4; start_cnt = 4'd3; end_div = 4'd2; end_cnt = 4'd1;
    push(2'd1, 18, "R4 pulses restart end timer");
    push(2'd2, 546, "R8 burst unaffected");
    open_on(1'b0, "R1 falling edge opens again");
    pulse_at(3);
    while (cyc < 5) step();
    vsync = 1'b1; step(); vsync = 1'b0;
    pulse_at(10);
    do @(negedge clk); while (phase != 2'd2);
    vsync = 1'b1; @(negedge clk); vsync = 1'b0;
    wait_video();
    repeat (4) begin
      @(negedge clk);
      chk(phase == 2'd0, "R8 no reopen after burst", int'(phase), 0);
    end

    // R5: largest divide, count one -> 1024
    start_div = 4'd10; start_cnt = 4'd0;
    push(2'd1, 1024, "R5 divide 1024");
    push(2'd2, 546, "R7 short burst");
    open_on(1'b0, "R1 opens");
    wait_video();

    // R5: clamped divider code
    start_div = 4'd15; start_cnt = 4'd0;
    push(2'd1, 1024, "R5 clamped code");
    push(2'd2, 546, "R7 short burst");
    open_on(1'b0, "R1 opens");
    wait_video();

    // R6: count code 0 with divide 1 -> one cycle; code 15 -> 16
    start_div = 4'd0; start_cnt = 4'd0;
    push(2'd1, 1, "R6 count code zero");
    push(2'd2, 546, "R7 short burst");
    open_on(1'b0, "R1 opens");
    wait_video();
    start_cnt = 4'd15;
    push(2'd1, 16, "R6 count code fifteen");
    push(2'd2, 546, "R7 short burst");
    open_on(1'b0, "R1 opens");
    wait_video();

    finish_run();
  end

endmodule